// File: doc/BRIEF.md
# USB 2.0 PHY Control Register Bank with Bit-Masked Writes

This block holds the control state for a USB 2.0 PHY behind a small 32-bit memory-mapped bus. The bus has an address, write data, a write strobe, a read strobe and read data. Each of the four word slots carries 16 bits. A write uses its upper half as a per-bit enable for its lower half, so software can set or clear one field without first reading the register back.

Three slots hold control state: port control at offset 0x00, mode control at 0x08 and suspend control at 0x0C. From these the bank drives four PHY controls: port reset, analog power-down, software-control select and a 6-bit suspend code. Offset 0x04 is a read-only status slot. It reports the VBUS-detect input after that input has passed through a synchronizer.

Read responses come from a two-state machine:
- `ST_IDLE`: no response is pending and the read data is 0.
- `ST_RESP`: the captured read word is on the read data bus.

The machine moves from `ST_IDLE` to `ST_RESP` on a read strobe. It stays in `ST_RESP` when reads come back to back. It returns to `ST_IDLE` on a cycle with no read strobe, and stays in `ST_IDLE` while no read arrives.

Top module: `phyctl_bank`

## Requirements
- R1: After reset, port reset, analog power-down and software select are 0, the suspend code is 0x01 and the read data is 0.
- R2: On a write to a control slot, lower bit n takes write-data bit n only when write-data bit n+16 is 1. Every other bit keeps its value.
- R3: In slot 0x00, bit 12 drives port reset (1 = reset asserted) and bit 13 drives analog power-down (1 = powered down, 0 = powered up).
- R4: In slot 0x08, bit 2 drives software-control select (1 = software control). In slot 0x0C, bits 5:0 drive the suspend code (0x2A = suspend, 0x01 = normal operation).
- R5: A read of slot 0x04 returns the VBUS-detect input in bit 14, delayed by SYNC_STAGES clocks. All its other bits are 0, and writes to 0x04 change nothing.
- R6: Bits 31:16 of every read word are 0.
- R7: A write to any offset other than 0x00, 0x04, 0x08 or 0x0C changes no output, and a read from such an offset returns 0.
- R8: Read data appears in the cycle after the read strobe and is 0 in any cycle not preceded by a read strobe. A read issued in the same cycle as a write returns the contents from before that write.
- R9: A PHY control output changes at the clock edge that captures the write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write word: bits 31:16 are the bit enables, bits 15:0 are the values |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| vbus_in | input | 1 | Asynchronous VBUS-detect input |
| phy_port_rst | output | 1 | PHY port reset |
| phy_ana_pwrdn | output | 1 | PHY analog power-down |
| phy_sw_sel | output | 1 | PHY software-control select |
| phy_susp | output | 6 | PHY suspend code |

## Verification
A wrong bit in a control slot reaches a PHY output at the edge after the faulty write. It also appears in the first read of that slot, and the per-clock model comparison catches it in that same cycle. A mask applied to the wrong half, or to a bit one position off, leaves an untouched neighbour bit changed, so the bench writes sparse masks over values with all bits set. A wrong response-machine state shows up as nonzero read data in an idle cycle, or as a read word arriving one cycle late.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = 16;
    localparam int NSLOT    = 4;
    localparam int SLOT_STEP = 4;

    localparam int IDX_PORT = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_MODE = 2;
    localparam int IDX_SUSP = 3;

    localparam int PORT_RST_BIT = 12;
    localparam int PWRDN_BIT    = 13;
    localparam int SWSEL_BIT    = 2;
    localparam int SUSP_LSB     = 0;
    localparam int SUSP_W       = 6;
    localparam int VBUS_BIT     = 14;

    localparam logic [HALF_W-1:0] SUSP_RST = 16'h0001;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic logic [HALF_W-1:0] slot_reset(input int idx);
        return (idx == IDX_SUSP) ? SUSP_RST : '0;
    endfunction
endpackage

// File: rtl/phyctl_decode.sv
module phyctl_decode
    import phyctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSLOT-1:0]  hit
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(i * SLOT_STEP);
        assign hit[i] = (addr == OFFS);
    end
endmodule

// File: rtl/phyctl_mreg.sv
module phyctl_mreg #(
    parameter int            W   = 16,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    logic [W-1:0] en_bits;
    logic [W-1:0] new_bits;
    logic [W-1:0] q_next;

    assign en_bits  = wdata[2*W-1:W];
    assign new_bits = wdata[W-1:0];

    always_comb begin
        q_next = q;
        if (we) begin
            q_next = (q & ~en_bits) | (new_bits & en_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/phyctl_sync.sv
module phyctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/phyctl_rsp.sv
module phyctl_rsp
    import phyctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rdata
);
    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd)  state_d = ST_RESP;
            ST_RESP: if (!rd) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd) word_q <= rd_word;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESP: rdata = word_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/phyctl_bank.sv
module phyctl_bank
    import phyctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              vbus_in,
    output logic              phy_port_rst,
    output logic              phy_ana_pwrdn,
    output logic              phy_sw_sel,
    output logic [5:0]        phy_susp
);
    logic [NSLOT-1:0]  hit;
    logic [HALF_W-1:0] slot_q [NSLOT];
    logic [HALF_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_word;
    logic              vbus_s;

    phyctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    phyctl_sync #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (vbus_in),
        .dout  (vbus_s)
    );

    always_comb begin
        stat_word = '0;
        stat_word[VBUS_BIT] = vbus_s;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i == IDX_STAT) begin : g_ro
            assign slot_q[i] = stat_word;
        end else begin : g_rw
            phyctl_mreg #(.W(HALF_W), .RST(slot_reset(i))) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (bus_wr & hit[i]),
                .wdata (bus_wdata),
                .q     (slot_q[i])
            );
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (hit[i]) rd_word[HALF_W-1:0] = rd_word[HALF_W-1:0] | slot_q[i];
        end
    end

    phyctl_rsp u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .rd_word (rd_word),
        .rdata   (bus_rdata)
    );

    assign phy_port_rst  = slot_q[IDX_PORT][PORT_RST_BIT];
    assign phy_ana_pwrdn = slot_q[IDX_PORT][PWRDN_BIT];
    assign phy_sw_sel    = slot_q[IDX_MODE][SWSEL_BIT];
    assign phy_susp      = slot_q[IDX_SUSP][SUSP_LSB +: SUSP_W];
endmodule

// File: rtl/phyctl_bank_chk.sv
module phyctl_bank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              phy_port_rst,
    input logic              phy_ana_pwrdn,
    input logic              phy_sw_sel,
    input logic [5:0]        phy_susp
);
    localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_SUSP = ADDR_W'(12);

    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr == A_PORT || bus_addr == A_MODE || bus_addr == A_SUSP);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phy_susp == 6'h01 && !phy_port_rst && !phy_ana_pwrdn && !phy_sw_sel));

    // R2
    susp_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SUSP) |=>
        phy_susp == (($past(phy_susp) & ~$past(bus_wdata[21:16])) |
                     ($past(bus_wdata[5:0]) & $past(bus_wdata[21:16]))));

    // R3
    port_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PORT) |=>
        phy_port_rst == ($past(bus_wdata[28]) ? $past(bus_wdata[12]) : $past(phy_port_rst)));

    // R3
    pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PORT) |=>
        phy_ana_pwrdn == ($past(bus_wdata[29]) ? $past(bus_wdata[13]) : $past(phy_ana_pwrdn)));

    // R5
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> (bus_rdata[13:0] == 14'h0 && !bus_rdata[15]));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    // R7
    no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable({phy_port_rst, phy_ana_pwrdn, phy_sw_sel, phy_susp}));

    // R8
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'h0);
endmodule

bind phyctl_bank phyctl_bank_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/phyctl_bank_tb.sv
`timescale 1ns/1ps
module phyctl_bank_tb_top;
    localparam int AW   = 8;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic          vbus_in = 1'b0;
    logic          phy_port_rst, phy_ana_pwrdn, phy_sw_sel;
    logic [5:0]    phy_susp;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phyctl_bank #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) dut_i (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
        .vbus_in, .phy_port_rst, .phy_ana_pwrdn, .phy_sw_sel, .phy_susp
    );

    // behavioural reference model
    logic [15:0] m_reg [4];
    bit          m_sync [$];
    logic [31:0] m_rdata;

    function automatic int slot_of(input logic [AW-1:0] a);
        case (int'(a))
            0: return 0;
            4: return 1;
            8: return 2;
            12: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg[0] = 16'h0; m_reg[1] = 16'h0; m_reg[2] = 16'h0; m_reg[3] = 16'h0001;
            m_sync.delete();
            for (int k = 0; k < SYNC; k++) m_sync.push_back(1'b0);
            m_rdata = 32'h0;
        end else begin
            int s;
            s = slot_of(bus_addr);
            if (bus_rd) begin
                if (s == 1)      m_rdata = {17'h0, m_sync[0], 14'h0};
                else if (s >= 0) m_rdata = {16'h0, m_reg[s]};
                else             m_rdata = 32'h0;
            end else begin
                m_rdata = 32'h0;
            end
            if (bus_wr && s >= 0 && s != 1) begin
                for (int n = 0; n < 16; n++)
                    if (bus_wdata[n+16]) m_reg[s][n] = bus_wdata[n];
            end
            m_sync.push_back(vbus_in);
            void'(m_sync.pop_front());
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 model port_rst", {31'h0, phy_port_rst}, {31'h0, m_reg[0][12]});
            chk("R3 model pwrdn",    {31'h0, phy_ana_pwrdn}, {31'h0, m_reg[0][13]});
            chk("R4 model sw_sel",   {31'h0, phy_sw_sel}, {31'h0, m_reg[2][2]});
            chk("R4 model susp",     {26'h0, phy_susp}, {26'h0, m_reg[3][5:0]});
            chk("R8 model rdata",    bus_rdata, m_rdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 port_rst", {31'h0, phy_port_rst}, 32'h0);
        chk("R1 pwrdn", {31'h0, phy_ana_pwrdn}, 32'h0);
        chk("R1 sw_sel", {31'h0, phy_sw_sel}, 32'h0);
        chk("R1 susp", {26'h0, phy_susp}, 32'h1);
        chk("R1 rdata", bus_rdata, 32'h0);
        do_read(8'h0C, rv);
        chk("R1 susp readback", rv, 32'h0000_0001);

        // R3 / R9 port reset with single-bit mask
        bus_addr = 8'h00; bus_wdata = 32'h1000_1000; bus_wr = 1'b1;
        #1 chk("R9 no change before edge", {31'h0, phy_port_rst}, 32'h0);
        @(negedge clk); bus_wr = 1'b0;
        chk("R3 port reset set", {31'h0, phy_port_rst}, 32'h1);
        chk("R9 changed at edge", {31'h0, phy_port_rst}, 32'h1);
        do_write(8'h00, 32'h2000_3000);
        chk("R2 pwrdn set", {31'h0, phy_ana_pwrdn}, 32'h1);
        chk("R2 port reset kept", {31'h0, phy_port_rst}, 32'h1);
        do_write(8'h00, 32'h1000_0000);
        chk("R3 port reset clear", {31'h0, phy_port_rst}, 32'h0);
        do_read(8'h00, rv);
        chk("R2 slot0 readback", rv, 32'h0000_2000);

        // R4 suspend code
        do_write(8'h0C, 32'h003F_002A);
        chk("R4 suspend code", {26'h0, phy_susp}, 32'h2A);
        do_write(8'h0C, 32'h0001_FFFF);
        chk("R2 suspend masked", {26'h0, phy_susp}, 32'h2B);
        do_read(8'h0C, rv);
        chk("R6 upper zero", rv, 32'h0000_002B);

        // R4 software select, full mask
        do_write(8'h08, 32'hFFFF_ABCD);
        chk("R4 sw_sel", {31'h0, phy_sw_sel}, 32'h1);
        do_read(8'h08, rv);
        chk("R2 full mask readback", rv, 32'h0000_ABCD);
        do_write(8'h08, 32'h0004_0000);
        chk("R4 sw_sel clear", {31'h0, phy_sw_sel}, 32'h0);

        // R7 unmapped
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'h03, 32'hFFFF_0000);
        chk("R7 outputs kept", {26'h0, phy_susp}, 32'h2B);
        chk("R7 pwrdn kept", {31'h0, phy_ana_pwrdn}, 32'h1);
        do_read(8'h10, rv);
        chk("R7 unmapped read", rv, 32'h0);
        do_read(8'h03, rv);
        chk("R7 misaligned read", rv, 32'h0);

        // R5 vbus status
        do_read(8'h04, rv);
        chk("R5 vbus low", rv, 32'h0);
        vbus_in = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        do_read(8'h04, rv);
        chk("R5 vbus high", rv, 32'h0000_4000);
        do_write(8'h04, 32'hFFFF_0000);
        do_read(8'h04, rv);
        chk("R5 write ignored", rv, 32'h0000_4000);
        vbus_in = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        do_read(8'h04, rv);
        chk("R5 vbus low again", rv, 32'h0);

        // R8 read with concurrent write, then idle
        bus_addr = 8'h0C; bus_wdata = 32'h003F_0001; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R8 read before write", bus_rdata, 32'h0000_002B);
        chk("R4 normal code", {26'h0, phy_susp}, 32'h01);
        @(negedge clk);
        chk("R8 idle zero", bus_rdata, 32'h0);

        // R8 back-to-back reads
        bus_addr = 8'h00; bus_rd = 1'b1;
        @(negedge clk);
        chk("R8 b2b first", bus_rdata, 32'h0000_2000);
        bus_addr = 8'h0C;
        @(negedge clk); bus_rd = 1'b0;
        chk("R8 b2b second", bus_rdata, 32'h0000_0001);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule